// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output pin. Bytes enter a small first-in first-out queue through a register port; whenever transmission is enabled and the shifter is free, the oldest byte is framed with a low start bit and a high stop bit and sent least significant bit first. Each bit lasts a fixed number of pulses of a baud tick input supplied from outside.

Two sticky flags let the host pace itself. The low-water flag rises whenever the queue holds no more than a programmed trigger level, so after seeing it the host may add up to (depth minus trigger) bytes without loss. The idle flag rises once the queue is empty and the last stop bit has left the pin. A flag is cleared only by a status read that returned 1 for it, followed by a status write carrying 0 in that bit. A queue-level register reports the number of bytes waiting.

To send a break, the host loads a pin-level bit and a select bit in the port register and then drops transmit enable; from then on the pin follows the pin-level bit.

Top module: `uart_txq`

## Requirements
- R1: The queue holds DEPTH (16) bytes; a write to address 0 enqueues reg_wdata[7:0], and a write while 16 bytes are held is dropped with no change to the queue.
- R2: A read of address 3 returns the number of queued bytes in bits [15:8] and zero in bits [7:0].
- R3: Each byte is sent as one low start bit, eight data bits least significant first, and one high stop bit, each bit lasting TICKS_PER_BIT (16) tick pulses; bytes leave in the order written.
- R4: A new frame starts only while transmit enable (address 2, bit 0) is 1; with it at 0 queued bytes stay queued.
- R5: Status bit 1 (low-water flag, address 1) becomes 1 on the cycle after the queue count is at or below the trigger level chosen by address 2 bits [2:1]: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R6: Status bit 0 (idle flag) is 1 after reset and becomes 1 on the cycle after the queue is empty and no frame is in progress.
- R7: A status write clears a flag bit written as 0 only if a status read since the previous status write returned 1 for that bit; a bit written as 1, or written as 0 without such a read, keeps its value, and a flag whose set condition still holds sets again.
- R8: The pin is high whenever no frame is in progress and the port override is not in force.
- R9: The port register (address 4) holds a pin level in bit 0 and a select in bit 1; while select is 1 and transmit enable is 0 the pin equals the pin level.
- R10: After reset the status reads 3, the queue level reads 0, the control and port registers read 0 and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per baud sub-interval |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| tx_o | output | 1 | Serial output pin |

## Verification
The bench keeps the default depth of 16 and 16 ticks per bit, and holds the tick input high so one bit lasts exactly 16 clocks and a full queue drains within a few thousand cycles. That makes the full-queue drop, a complete 16-frame burst in write order and the trigger levels 4 and 8 all reachable in one short run, together with the armed and unarmed clear paths and the break override.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef enum logic [2:0] {
        ADR_DATA  = 3'd0,
        ADR_STAT  = 3'd1,
        ADR_CTRL  = 3'd2,
        ADR_LEVEL = 3'd3,
        ADR_PORT  = 3'd4
    } reg_adr_e;

    typedef struct packed {
        logic       tx_en;
        logic [1:0] trig_sel;
        logic       pin_lvl;
        logic       pin_sel;
    } ctl_t;

    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        return 8'd1 << sel;
    endfunction

endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] rp;
        logic [AW-1:0] wp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign rdata = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/uart_txq_shifter.sv
module uart_txq_shifter #(
    parameter int TICKS_PER_BIT = 16,
    parameter int W             = 8,
    localparam int FRAME        = W + 2,
    localparam int TW           = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int BW           = $clog2(FRAME)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] data,
    output logic         busy,
    output logic         line
);
    typedef struct packed {
        logic             busy;
        logic [FRAME-1:0] sh;
        logic [TW-1:0]    tcnt;
        logic [BW-1:0]    bcnt;
    } st_t;

    st_t st_d, st_q;

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sh[0] : 1'b1;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.sh   = {1'b1, data, 1'b0};
                st_d.tcnt = '0;
                st_d.bcnt = '0;
            end
        end else if (tick) begin
            if (st_q.tcnt == TW'(TICKS_PER_BIT - 1)) begin
                st_d.tcnt = '0;
                if (st_q.bcnt == BW'(FRAME - 1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.sh   = {1'b1, st_q.sh[FRAME-1:1]};
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_txq_flags.sv
module uart_txq_flags #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [1:0]    trig_sel,
    input  logic          q_empty,
    input  logic          tx_busy,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic [1:0]    wbits,
    output logic          low_o,
    output logic          idle_o,
    output logic [1:0]    arm_o
);
    import uart_txq_pkg::*;

    typedef struct packed {
        logic       low;
        logic       idle;
        logic [1:0] arm;
    } st_t;

    st_t  st_d, st_q;
    logic low_set, idle_set;

    assign low_set  = (8'(count) <= trig_level(trig_sel));
    assign idle_set = q_empty && !tx_busy;
    assign low_o    = st_q.low;
    assign idle_o   = st_q.idle;
    assign arm_o    = st_q.arm;

    always_comb begin
        st_d = st_q;
        if (stat_rd) st_d.arm = st_q.arm | {st_q.low, st_q.idle};
        if (stat_wr) begin
            if (st_q.arm[1] && !wbits[1]) st_d.low  = 1'b0;
            if (st_q.arm[0] && !wbits[0]) st_d.idle = 1'b0;
            st_d.arm = '0;
        end
        if (low_set)  st_d.low  = 1'b1;
        if (idle_set) st_d.idle = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{low: 1'b1, idle: 1'b1, arm: 2'b00};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    localparam int CW           = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        tx_o
);
    import uart_txq_pkg::*;

    ctl_t ctl_d, ctl_q;

    logic          q_push, q_pop, q_empty, q_full;
    logic [7:0]    q_head;
    logic [CW-1:0] q_count;
    logic          sh_busy, sh_line, start;
    logic          stat_rd, stat_wr;
    logic          flag_low, flag_idle;
    logic [1:0]    flag_arm;
    logic          override;

    assign q_push   = reg_wr && (reg_addr == ADR_DATA);
    assign stat_rd  = reg_rd && (reg_addr == ADR_STAT);
    assign stat_wr  = reg_wr && (reg_addr == ADR_STAT);
    assign start    = ctl_q.tx_en && !sh_busy && !q_empty;
    assign q_pop    = start;
    assign override = ctl_q.pin_sel && !ctl_q.tx_en;
    assign tx_o     = override ? ctl_q.pin_lvl : sh_line;

    uart_txq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (reg_wdata[7:0]),
        .pop   (q_pop),
        .rdata (q_head),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    uart_txq_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT), .W(8)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .start (start),
        .data  (q_head),
        .busy  (sh_busy),
        .line  (sh_line)
    );

    uart_txq_flags #(.CW(CW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (q_count),
        .trig_sel (ctl_q.trig_sel),
        .q_empty  (q_empty),
        .tx_busy  (sh_busy),
        .stat_rd  (stat_rd),
        .stat_wr  (stat_wr),
        .wbits    (reg_wdata[1:0]),
        .low_o    (flag_low),
        .idle_o   (flag_idle),
        .arm_o    (flag_arm)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && reg_addr == ADR_CTRL) begin
            ctl_d.tx_en    = reg_wdata[0];
            ctl_d.trig_sel = reg_wdata[2:1];
        end
        if (reg_wr && reg_addr == ADR_PORT) begin
            ctl_d.pin_lvl = reg_wdata[0];
            ctl_d.pin_sel = reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_STAT:  reg_rdata = {14'd0, flag_low, flag_idle};
            ADR_CTRL:  reg_rdata = {13'd0, ctl_q.trig_sel, ctl_q.tx_en};
            ADR_LEVEL: reg_rdata = {8'(q_count), 8'd0};
            ADR_PORT:  reg_rdata = {14'd0, ctl_q.pin_sel, ctl_q.pin_lvl};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          push,
    input logic          pop,
    input logic          empty,
    input logic          busy,
    input logic          tx_en,
    input logic          pin_sel,
    input logic          pin_lvl,
    input logic [1:0]    trig_sel,
    input logic          tx,
    input logic          stat_wr,
    input logic [1:0]    arm,
    input logic          idle,
    input logic          low
);
    import uart_txq_pkg::*;

    logic [7:0] cnt8;
    assign cnt8 = 8'(count);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt8 <= 8'(DEPTH));

    assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !$rose(busy));

    assert_low_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt8 <= trig_level(trig_sel)) |=> low);

    assert_idle_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !busy) |=> idle);

    assert_no_blind_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !arm[0] && idle) |=> idle);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(pin_sel && !tx_en)) |-> tx);

    assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel && !tx_en) |-> (tx == pin_lvl));
endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (q_count),
    .full     (q_full),
    .push     (q_push),
    .pop      (q_pop),
    .empty    (q_empty),
    .busy     (sh_busy),
    .tx_en    (ctl_q.tx_en),
    .pin_sel  (ctl_q.pin_sel),
    .pin_lvl  (ctl_q.pin_lvl),
    .trig_sel (ctl_q.trig_sel),
    .tx       (tx_o),
    .stat_wr  (stat_wr),
    .arm      (flag_arm),
    .idle     (flag_idle),
    .low      (flag_low)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   mon_en   = 1'b1;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    uart_txq u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_o(tx_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, input bit accepted);
        wr(3'd0, {8'd0, b});
        if (accepted) exp_q.push_back(b);
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        repeat (30) @(negedge clk);
    endtask

    // Monitor: decode frames off the pin and compare with the scoreboard (R3)
    initial begin
        logic [7:0] got;
        logic [7:0] want;
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && tx_o === 1'b0) begin
                repeat (7) @(negedge clk);
                check("R3 start bit", {15'd0, tx_o}, 16'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (16) @(negedge clk);
                    got[i] = tx_o;
                end
                repeat (16) @(negedge clk);
                check("R3 stop bit", {15'd0, tx_o}, 16'd1);
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame", {8'd0, got}, 16'hxxxx);
                end else begin
                    want = exp_q.pop_front();
                    check("R3 byte order", {8'd0, got}, {8'd0, want});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R6 idle flag after reset
        rd(3'd1, v); check("R10 status", v, 16'h0003);
        rd(3'd3, v); check("R10 level", v, 16'h0000);
        rd(3'd2, v); check("R10 ctrl", v, 16'h0000);
        rd(3'd4, v); check("R10 port", v, 16'h0000);
        check("R10 pin", {15'd0, tx_o}, 16'd1);

        // R7 writing 1s has no effect
        wr(3'd1, 16'hFFFF);
        rd(3'd1, v); check("R7 write of 1", v, 16'h0003);
        wr(3'd1, 16'h0000); // consumes the arm from the read just above
        // trigger 4, disabled
        wr(3'd2, 16'h0004);
        for (int i = 0; i < 5; i++) push_byte(8'h30 + 8'(i), 1'b1);
        rd(3'd3, v); check("R2 level five", v, 16'h0500);
        repeat (40) @(negedge clk);
        check("R4 pin held while disabled", {15'd0, tx_o}, 16'd1);
        rd(3'd3, v); check("R4 queue kept", v, 16'h0500);

        // R7 write of 0 with no read first leaves flags
        wr(3'd1, 16'h0000);
        rd(3'd1, v); check("R7 blind clear ignored", v, 16'h0003);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); check("R7 armed clear", v, 16'h0000);

        // R5 trigger 8: count 5 is at or below 8
        wr(3'd2, 16'h0006);
        rd(3'd1, v); check("R5 low flag at trigger 8", v, 16'h0002);
        wr(3'd1, 16'h0000);
        rd(3'd1, v); check("R7 reset while condition holds", v, 16'h0002);

        // R1 overflow: 11 more accepted, one dropped
        for (int i = 0; i < 11; i++) push_byte(8'h80 + 8'(i * 13), 1'b1);
        push_byte(8'hEE, 1'b0);
        rd(3'd3, v); check("R1 full level", v, 16'h1000);

        // R3 drain in order with transmit enabled
        wr(3'd2, 16'h0001);
        wait_drain();
        check("R3 all frames seen", 16'(exp_q.size()), 16'd0);
        rd(3'd1, v); check("R6 idle after drain", v & 16'h0001, 16'h0001);
        rd(3'd3, v); check("R2 level empty", v, 16'h0000);
        check("R8 pin idle high", {15'd0, tx_o}, 16'd1);

        // R3 edge patterns
        push_byte(8'h00, 1'b1);
        push_byte(8'hFF, 1'b1);
        push_byte(8'hA5, 1'b1);
        wait_drain();
        check("R3 patterns done", 16'(exp_q.size()), 16'd0);

        // R9 break through port override
        mon_en = 1'b0;
        wr(3'd4, 16'h0002);
        check("R9 override inactive while enabled", {15'd0, tx_o}, 16'd1);
        wr(3'd2, 16'h0000);
        check("R9 break low", {15'd0, tx_o}, 16'd0);
        wr(3'd4, 16'h0003);
        check("R9 level high", {15'd0, tx_o}, 16'd1);
        wr(3'd4, 16'h0000);
        check("R8 pin high without override", {15'd0, tx_o}, 16'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule